// File: doc/BRIEF.md
# Threshold-Driven DMA Staging FIFO

This block is a small byte-wide staging buffer between a serial network engine and a DMA engine. It tracks how many bytes it holds and uses that level to decide when to raise a bus request to the DMA side. In receive direction the network side fills the buffer and the DMA side drains it. In transmit direction the DMA side fills it and the network side drains it. The bus-cycle timing of the DMA engine is handled elsewhere.

In receive direction a request rises once the level passes a programmable threshold. The amount past the threshold depends on whether the DMA moves bytes or 16-bit words. At the start of each frame, the first request is also held back until the destination address has been fully buffered. The overrun flag is raised early, several bytes before the storage is physically full, so that the DMA has headroom to catch up. If the address filter rejects a frame, the controller drops all buffered bytes in a single cycle.

Top module: `netdma_fifo`

## Requirements
- R1: Bytes are read out in the order they were written. Up to 16 bytes are stored. `rd_data` always shows the oldest stored byte, without a read latency. A write while 16 bytes are held is dropped.
- R2: `thr_sel` picks the threshold T: 0 selects 2 bytes, 1 selects 4, 2 selects 8 and 3 selects 12.
- R3: In receive direction (`dir_tx`=0) with `word_mode`=0, `bus_req` rises on the same clock edge at which the level first reaches T+1, provided the frame hold (R5) is released.
- R4: In receive direction with `word_mode`=1, `bus_req` rises on the clock edge at which the level first reaches T+2.
- R5: A `frame_start` pulse re-arms a hold. While the hold is armed, no receive request rises until the level is at least 8. The first request releases the hold.
- R6: `overrun` is set on the edge at which an accepted write brings the level to 13 or more. It stays set until a `flag_clr` pulse, and a set in the same cycle wins over the clear.
- R7: An `addr_reject` pulse empties the FIFO and drops `bus_req` on the next edge. Any write or read in that same cycle is discarded.
- R8: In transmit direction (`dir_tx`=1), an idle controller raises `bus_req` when the free space (16 minus the level) is at least T.
- R9: A read while the FIFO is empty sets the sticky `underrun` flag and leaves the level at 0. The flag is cleared by `flag_clr`.
- R10: A raised request drops after T DMA transfers have been accepted. DMA transfers are reads in receive direction and writes in transmit direction. A `frame_end` pulse also drops the request. After a drop, the request may rise again one cycle later if its condition still holds.
- R11: After reset, the level is 0, `bus_req`, `overrun` and `underrun` are low, and the frame hold is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 0 = receive (network writes, DMA reads), 1 = transmit |
| word_mode | input | 1 | 1 = DMA moves 16-bit words, 0 = bytes |
| thr_sel | input | 2 | Threshold select (R2) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Oldest stored byte |
| frame_start | input | 1 | Start-of-frame pulse, re-arms the address hold |
| frame_end | input | 1 | End-of-frame pulse, drops the request |
| addr_reject | input | 1 | Address filter rejected the frame: empty the FIFO |
| flag_clr | input | 1 | Clears the sticky overrun and underrun flags |
| bus_req | output | 1 | Bus request to the DMA engine |
| overrun | output | 1 | Sticky early-overrun flag |
| underrun | output | 1 | Sticky read-while-empty flag |
| level | output | 5 | Number of stored bytes (0 to 16) |

## Verification
The assertions check the following on every cycle:
- the level never exceeds 16;
- once set, the overrun and underrun flags hold until cleared;
- the early-overrun point sets the flag;
- a reject empties the FIFO and drops the request;
- a frame end drops the request;
- no receive request rises below 8 bytes while a frame hold is armed.

Only the bench scenarios can show the following:
- the exact edge at which the request rises for each threshold and for byte versus word mode;
- the burst length after which the request falls;
- the transmit free-space rule;
- that bytes leave in the order they entered, including when excess writes to a full FIFO are dropped.

// File: rtl/netdma_pkg.sv
package netdma_pkg;

    typedef enum logic [1:0] {
        THR_2  = 2'd0,
        THR_4  = 2'd1,
        THR_8  = 2'd2,
        THR_12 = 2'd3
    } thr_sel_e;

    // Threshold in bytes for a select code (R2)
    function automatic logic [4:0] thr_bytes(input logic [1:0] sel);
        logic [4:0] t;
        case (thr_sel_e'(sel))
            THR_2:   t = 5'd2;
            THR_4:   t = 5'd4;
            THR_8:   t = 5'd8;
            default: t = 5'd12;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/netdma_store.sv
module netdma_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_acc,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_acc,
    output logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d = '0;
        end else begin
            if (wr_acc) ptr_d.wptr = ptr_q.wptr + AW'(1);
            if (rd_acc) ptr_d.rptr = ptr_q.rptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_acc) mem_q[ptr_q.wptr] <= wr_data;
    end

    assign rd_data = mem_q[ptr_q.rptr];

endmodule

// File: rtl/netdma_level.sv
module netdma_level #(
    parameter int DEPTH     = 16,
    parameter int OVR_LEVEL = 13,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          flag_clr,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_acc,
    output logic          rd_acc,
    output logic [CW-1:0] count_q_o,
    output logic [CW-1:0] count_d_o,
    output logic          overrun,
    output logic          underrun
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] OVR_C  = CW'(OVR_LEVEL);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          ovr;
        logic          unr;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic underflow;

    always_comb begin
        wr_acc    = wr_en && !clear && (lvl_q.count < FULL_C);
        rd_acc    = rd_en && !clear && (lvl_q.count != '0);
        underflow = rd_en && !clear && (lvl_q.count == '0);
        lvl_d     = lvl_q;
        if (clear) lvl_d.count = '0;
        else       lvl_d.count = lvl_q.count + CW'(wr_acc) - CW'(rd_acc);
        lvl_d.ovr = (lvl_q.ovr && !flag_clr) || (wr_acc && lvl_d.count >= OVR_C);
        lvl_d.unr = (lvl_q.unr && !flag_clr) || underflow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign count_q_o = lvl_q.count;
    assign count_d_o = lvl_d.count;
    assign overrun   = lvl_q.ovr;
    assign underrun  = lvl_q.unr;

endmodule

// File: rtl/netdma_req.sv
module netdma_req
    import netdma_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int HOLD_BYTES = 8,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_tx,
    input  logic          word_mode,
    input  logic [1:0]    thr_sel,
    input  logic [CW-1:0] count_d,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          clear,
    output logic          bus_req
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD_BYTES);

    typedef struct packed {
        logic          req;
        logic          released;
        logic [CW-1:0] burst;
    } req_t;

    req_t st_d, st_q;
    logic [CW-1:0] thr, rx_trig;
    logic xfer, held_ok, rx_cond, tx_cond, cond, burst_done;

    always_comb begin
        thr        = CW'(thr_bytes(thr_sel));
        rx_trig    = thr + (word_mode ? CW'(2) : CW'(1));
        xfer       = dir_tx ? wr_acc : rd_acc;
        held_ok    = (st_q.released && !frame_start) || (count_d >= HOLD_C);
        rx_cond    = (count_d >= rx_trig) && held_ok;
        tx_cond    = (FULL_C - count_d) >= thr;
        cond       = dir_tx ? tx_cond : rx_cond;
        burst_done = st_q.req && xfer && ((st_q.burst + CW'(1)) == thr);

        st_d = st_q;
        if (clear || frame_end) begin
            st_d.req   = 1'b0;
            st_d.burst = '0;
        end else if (st_q.req) begin
            if (burst_done) begin
                st_d.req   = 1'b0;
                st_d.burst = '0;
            end else begin
                st_d.burst = st_q.burst + CW'(xfer);
            end
        end else begin
            st_d.req   = cond;
            st_d.burst = '0;
        end
        st_d.released = frame_start ? 1'b0
                                    : (st_q.released || (!st_q.req && st_d.req));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_req = st_q.req;

endmodule

// File: rtl/netdma_fifo.sv
module netdma_fifo #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter int OVR_LEVEL  = 13,
    parameter int HOLD_BYTES = 8,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_tx,
    input  logic          word_mode,
    input  logic [1:0]    thr_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          addr_reject,
    input  logic          flag_clr,
    output logic          bus_req,
    output logic          overrun,
    output logic          underrun,
    output logic [CW-1:0] level
);

    logic          wr_acc, rd_acc;
    logic [CW-1:0] count_d;

    netdma_level #(.DEPTH(DEPTH), .OVR_LEVEL(OVR_LEVEL)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (addr_reject),
        .flag_clr  (flag_clr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .count_q_o (level),
        .count_d_o (count_d),
        .overrun   (overrun),
        .underrun  (underrun)
    );

    netdma_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_reject),
        .wr_acc  (wr_acc),
        .wr_data (wr_data),
        .rd_acc  (rd_acc),
        .rd_data (rd_data)
    );

    netdma_req #(.DEPTH(DEPTH), .HOLD_BYTES(HOLD_BYTES)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_tx      (dir_tx),
        .word_mode   (word_mode),
        .thr_sel     (thr_sel),
        .count_d     (count_d),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .clear       (addr_reject),
        .bus_req     (bus_req)
    );

endmodule

// File: rtl/netdma_fifo_chk.sv
module netdma_fifo_chk #(
    parameter int DEPTH      = 16,
    parameter int OVR_LEVEL  = 13,
    parameter int HOLD_BYTES = 8,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_tx,
    input logic          wr_en,
    input logic          rd_en,
    input logic          frame_start,
    input logic          frame_end,
    input logic          addr_reject,
    input logic          flag_clr,
    input logic          bus_req,
    input logic          overrun,
    input logic          underrun,
    input logic [CW-1:0] level
);

    // Checker-side copy of "hold armed": set by frame start, cleared by a request
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           armed_q <= 1'b1;
        else if (frame_start) armed_q <= 1'b1;
        else if (bus_req)     armed_q <= 1'b0;
    end

    // R1: level never exceeds storage
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R6: overrun sets at the early point
    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !addr_reject && level == CW'(OVR_LEVEL - 1)) |=> overrun);

    // R6: overrun is sticky
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flag_clr) |=> overrun);

    // R9: read while empty sets underrun, level stays empty
    a_r9_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !addr_reject && level == '0) |=> (underrun && level == '0));

    // R9: underrun is sticky
    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !flag_clr) |=> underrun);

    // R7: reject empties and drops the request
    a_r7_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
        addr_reject |=> (level == '0 && !bus_req));

    // R10: frame end drops the request
    a_r10_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !bus_req);

    // R5: no receive request below the hold level while armed
    a_r5_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && !frame_start && armed_q && !bus_req && !addr_reject)
            |=> (!bus_req || level >= CW'(HOLD_BYTES)));

endmodule

bind netdma_fifo netdma_fifo_chk #(
    .DEPTH(DEPTH), .OVR_LEVEL(OVR_LEVEL), .HOLD_BYTES(HOLD_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .wr_en(wr_en), .rd_en(rd_en),
    .frame_start(frame_start), .frame_end(frame_end), .addr_reject(addr_reject),
    .flag_clr(flag_clr), .bus_req(bus_req), .overrun(overrun),
    .underrun(underrun), .level(level)
);

// File: tb/netdma_fifo_tb.sv
module netdma_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_tx = 1'b0, word_mode = 1'b0;
    logic [1:0] thr_sel = 2'd2;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       frame_start = 1'b0, frame_end = 1'b0, addr_reject = 1'b0, flag_clr = 1'b0;
    logic       bus_req, overrun, underrun;
    logic [4:0] level;

    int n_chk = 0;
    int n_fail = 0;
    int model_cnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] seed = 8'h40;
    bit done = 1'b0;

    always #5 clk = ~clk;

    netdma_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .word_mode(word_mode),
        .thr_sel(thr_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .frame_start(frame_start), .frame_end(frame_end),
        .addr_reject(addr_reject), .flag_clr(flag_clr), .bus_req(bus_req),
        .overrun(overrun), .underrun(underrun), .level(level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design delivers them (R1)
    always @(negedge clk) begin
        if (rst_n && rd_en && !addr_reject && level != 5'd0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 order (queue empty)", rd_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R1 order", rd_data, e);
            end
        end
    end

    // One clock of stimulus; inputs driven off-edge, results sampled just after the edge
    task automatic cyc(input bit w, input bit r, input bit fs = 0, input bit fe = 0,
                       input bit rj = 0, input bit fc = 0);
        @(posedge clk); #2;
        wr_en = w; rd_en = r; frame_start = fs; frame_end = fe;
        addr_reject = rj; flag_clr = fc;
        wr_data = seed;
        if (rj) begin
            exp_q.delete();
            model_cnt = 0;
        end else begin
            if (r && model_cnt > 0) model_cnt--;
            if (w && model_cnt < 16) begin
                exp_q.push_back(seed);
                model_cnt++;
            end
        end
        if (w) seed = seed + 8'd7;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; frame_start = 0; frame_end = 0;
        addr_reject = 0; flag_clr = 0;
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0);
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(level == 0 && !bus_req && !overrun && !underrun, "R11 reset outputs", level, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!bus_req && level == 0, "R11 idle after reset", bus_req, 0);

        // R3: byte mode, threshold 8 (R2 code 2) -> request at 9th byte
        cyc(0, 0, 1);
        writes(8);
        check(!bus_req, "R3 no request at 8 bytes", bus_req, 0);
        writes(1);
        check(bus_req && level == 9, "R3 request at 9th byte", bus_req, 1);
        reads(7);
        check(bus_req, "R10 still requesting inside burst", bus_req, 1);
        reads(1);
        check(!bus_req && level == 1, "R10 drop after burst of 8", bus_req, 0);
        cyc(0, 0);
        check(!bus_req, "R10 no re-raise below trigger", bus_req, 0);
        cyc(0, 0, 0, 1, 1);
        check(level == 0, "R7 reject empties", level, 0);

        // R4: word mode, threshold 8 -> request at 10th byte
        word_mode = 1'b1;
        cyc(0, 0, 1);
        writes(9);
        check(!bus_req, "R4 no request at 9 bytes", bus_req, 0);
        writes(1);
        check(bus_req && level == 10, "R4 request at 10th byte", bus_req, 1);
        cyc(0, 0, 0, 0, 1);
        check(!bus_req && level == 0, "R7 reject drops request", bus_req, 0);
        word_mode = 1'b0;

        // R5: byte mode threshold 2 (code 0): held until 8 bytes
        thr_sel = 2'd0;
        cyc(0, 0, 1);
        writes(7);
        check(!bus_req && level == 7, "R5 held below 8 bytes", bus_req, 0);
        writes(1);
        check(bus_req, "R5 first request at 8 bytes", bus_req, 1);
        reads(2);
        check(!bus_req && level == 6, "R10 drop after burst of 2", bus_req, 0);
        cyc(0, 0);
        check(bus_req, "R2 re-raise at 6 bytes, threshold 2", bus_req, 1);
        cyc(0, 0, 0, 1);
        check(!bus_req, "R10 frame end drops request", bus_req, 0);
        cyc(0, 0, 0, 0, 1);

        // R6: early overrun at 13th byte, writes past 16 dropped
        thr_sel = 2'd3;
        cyc(0, 0, 1);
        writes(12);
        check(!overrun, "R6 no overrun at 12 bytes", overrun, 0);
        writes(1);
        check(overrun && level == 13, "R6 overrun at 13th byte", overrun, 1);
        writes(5);
        check(level == 16, "R1 writes beyond 16 dropped", level, 16);
        cyc(0, 0, 0, 0, 0, 1);
        check(!overrun, "R6 overrun cleared", overrun, 0);
        reads(16);
        check(level == 0, "R1 drained", level, 0);
        cyc(0, 1);
        check(underrun && level == 0, "R9 underrun on empty read", underrun, 1);
        cyc(0, 0);
        check(underrun, "R9 underrun sticky", underrun, 1);
        cyc(0, 0, 0, 0, 0, 1);
        check(!underrun, "R9 underrun cleared", underrun, 0);

        // R8: transmit, threshold 4
        @(posedge clk); #2;
        dir_tx = 1'b1; thr_sel = 2'd1;
        cyc(0, 0);
        check(bus_req, "R8 request with 16 free", bus_req, 1);
        writes(4);
        check(!bus_req && level == 4, "R10 tx drop after 4 writes", bus_req, 0);
        cyc(0, 0);
        check(bus_req, "R8 re-raise with 12 free", bus_req, 1);
        cyc(0, 0, 0, 1);
        check(!bus_req, "R10 tx frame end drops", bus_req, 0);
        cyc(0, 0);
        writes(4); cyc(0, 0);
        writes(4); cyc(0, 0);
        check(bus_req && level == 12, "R8 request with 4 free", bus_req, 1);
        writes(4); cyc(0, 0);
        check(!bus_req && level == 16, "R8 no request when full", bus_req, 0);
        reads(4);
        check(bus_req && level == 12, "R8 request after drain to 4 free", bus_req, 1);
        reads(12);
        check(level == 0, "R1 tx drained", level, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule